// File: doc/BRIEF.md
# Per-destination interrupt rate pacer

This block limits how often each of eight interrupt destinations can be signalled. Each destination has its own 32-bit countdown pacer, and software programs it through a plain register bus. When software writes a count, the counter loads that count at once and then decreases by one on every clock. When it reaches zero, the pacer is armed. An armed pacer sends one single-cycle pulse on its destination's interrupt line when that destination's pending-status vector (an input) has any bit set. If the vector is already non-zero at expiry, the pulse follows at once. Otherwise the pulse waits until a bit becomes set.

After its pulse, a pacer sits spent at zero and stays silent until software writes its register again. A write of zero arms the pacer directly. The block leaves reset with every pacer armed, so the first pending interrupt on each destination goes through at once. Reads return the count that software last wrote to the addressed pacer.

Top module: `irp_pacer_top`

## Requirements
- R1: After reset, every `irq_o` bit is 0, every pacer register reads 0x00000000, and every pacer is armed: the first cycle in which its pending lane becomes non-zero produces a pulse.
- R2: Pacer n is at byte address 0x320 + 4·n (n = 0..7). A read (`rd_en_i` high for one cycle) places the value last written to that pacer on `rdata_o` after the next rising edge.
- R3: A write of a non-zero count V at rising edge k loads the counter. With the pending lane non-zero, the pacer's `irq_o` bit is 1 exactly in the cycle after edge k+V+1, and is 0 in the cycles before it.
- R4: A write of zero arms the pacer at once. With the pending lane non-zero, the pulse appears after the edge that follows the write.
- R5: If the pending lane is all zero when the counter expires, no pulse is issued. The pulse is issued after the first edge at which the lane is non-zero.
- R6: Each arming yields at most one pulse. A spent pacer gives no further pulse while its pending lane stays set, until its register is written again.
- R7: Every pulse on `irq_o` lasts exactly one clock cycle.
- R8: A write to a pacer cancels any pulse that would otherwise be issued at the same edge, and the countdown restarts from the new value. This also holds while a countdown is in progress.
- R9: A write or read at an address that is not a word-aligned pacer address (below 0x320, above 0x33C, or with non-zero bits [1:0]) changes no pacer, raises no pulse, and a read there returns 0.
- R10: The pacers are independent: a write or expiry on one never changes the `irq_o` bit or the register value of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| rd_en_i | input | 1 | Register read strobe, one cycle per read |
| addr_i | input | 16 | Byte address of the access |
| wdata_i | input | 32 | Count written to the addressed pacer |
| rdata_o | output | 32 | Read data, valid after the edge that takes the read strobe |
| pend_i | input | NUM_CH·PEND_W | Pending-status lanes, lane n at bits [n·PEND_W +: PEND_W] |
| irq_o | output | NUM_CH | One-cycle interrupt pulse per destination |

## Verification
Two things can land on the same edge: a software write, and an armed pacer seeing its pending lane become non-zero. The write must win, so the pulse is dropped and the countdown restarts. The bench provokes this by raising the pending lane of an armed pacer in the same cycle that it writes that pacer. It also rewrites a pacer partway through a countdown. In both cases it checks the `irq_o` vector in every cycle: no pulse may follow the write at once, and exactly one pulse must come at the cycle computed from the new count.

// File: rtl/irp_pkg.sv
package irp_pkg;

    localparam int CNT_W  = 32;
    localparam int ADDR_W = 16;

    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [ADDR_W-1:0] addr_t;

    // Pacer phase: counting down, expired and waiting to fire, or fired.
    typedef enum logic [1:0] {
        PC_ARMED = 2'd0,
        PC_COUNT = 2'd1,
        PC_SPENT = 2'd2
    } pc_state_e;

    // One register-bus access as seen by the block.
    typedef struct packed {
        logic  wr;
        logic  rd;
        addr_t addr;
        cnt_t  data;
    } bus_req_t;

    // Per-channel load command.
    typedef struct packed {
        logic load;
        cnt_t value;
    } load_cmd_t;

    // True when addr selects a word-aligned slot in [base, base + 4*n_ch).
    function automatic logic slot_hit(input addr_t addr, input addr_t base, input int n_ch);
        addr_t off;
        off = addr - base;
        return (addr >= base) && (off[1:0] == 2'b00) && (int'(off >> 2) < n_ch);
    endfunction

    // Slot number of an address; only meaningful when slot_hit is true.
    function automatic int slot_num(input addr_t addr, input addr_t base);
        addr_t off;
        off = addr - base;
        return int'(off >> 2);
    endfunction

endpackage

// File: rtl/irp_decode.sv
module irp_decode
    import irp_pkg::*;
#(
    parameter int    NUM_CH    = 8,
    parameter addr_t BASE_ADDR = 16'h0320,
    localparam int   IDX_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              wr,
    input  logic              rd,
    input  addr_t             addr,
    output logic [NUM_CH-1:0] wr_sel,
    output logic              rd_hit,
    output logic [IDX_W-1:0]  rd_idx
);

    logic             hit;
    logic [IDX_W-1:0] idx;

    always_comb begin
        hit = slot_hit(addr, BASE_ADDR, NUM_CH);
        idx = hit ? IDX_W'(slot_num(addr, BASE_ADDR)) : '0;
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_sel
        assign wr_sel[g] = wr && hit && (idx == IDX_W'(g));
    end

    assign rd_hit = rd && hit;
    assign rd_idx = idx;

endmodule

// File: rtl/irp_channel.sv
module irp_channel
    import irp_pkg::*;
#(
    parameter int PEND_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  load_cmd_t         cmd,
    input  logic [PEND_W-1:0] pend,
    output cnt_t              shadow,
    output logic              irq
);

    pc_state_e state_q;
    cnt_t      cnt_q;
    cnt_t      shadow_q;
    logic      irq_q;
    logic      pend_any;

    assign pend_any = |pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= PC_ARMED;
            cnt_q    <= '0;
            shadow_q <= '0;
            irq_q    <= 1'b0;
        end else if (cmd.load) begin
            // A write always wins: any pulse due at this edge is dropped.
            shadow_q <= cmd.value;
            cnt_q    <= cmd.value;
            state_q  <= (cmd.value == '0) ? PC_ARMED : PC_COUNT;
            irq_q    <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            unique case (state_q)
                PC_COUNT: begin
                    cnt_q <= cnt_q - 1'b1;
                    if (cnt_q == cnt_t'(1)) begin
                        state_q <= PC_ARMED;
                    end
                end
                PC_ARMED: begin
                    if (pend_any) begin
                        irq_q   <= 1'b1;
                        state_q <= PC_SPENT;
                    end
                end
                PC_SPENT: begin
                    state_q <= PC_SPENT;
                end
                default: begin
                    state_q <= PC_SPENT;
                end
            endcase
        end
    end

    assign shadow = shadow_q;
    assign irq    = irq_q;

endmodule

// File: rtl/irp_rdmux.sv
module irp_rdmux
    import irp_pkg::*;
#(
    parameter int  NUM_CH = 8,
    localparam int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd,
    input  logic             hit,
    input  logic [IDX_W-1:0] idx,
    input  cnt_t             values [NUM_CH],
    output cnt_t             rdata
);

    cnt_t rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (rd) begin
            rdata_q <= hit ? values[idx] : '0;
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/irp_pacer_top.sv
module irp_pacer_top
    import irp_pkg::*;
#(
    parameter int    NUM_CH    = 8,
    parameter int    PEND_W    = 8,
    parameter addr_t BASE_ADDR = 16'h0320
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en_i,
    input  logic                     rd_en_i,
    input  logic [15:0]              addr_i,
    input  logic [31:0]              wdata_i,
    output logic [31:0]              rdata_o,
    input  logic [NUM_CH*PEND_W-1:0] pend_i,
    output logic [NUM_CH-1:0]        irq_o
);

    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    bus_req_t          req;
    logic [NUM_CH-1:0] wr_sel;
    logic              rd_hit;
    logic [IDX_W-1:0]  rd_idx;
    cnt_t              shadows [NUM_CH];

    always_comb begin
        req.wr   = wr_en_i;
        req.rd   = rd_en_i;
        req.addr = addr_i;
        req.data = wdata_i;
    end

    irp_decode #(.NUM_CH(NUM_CH), .BASE_ADDR(BASE_ADDR)) u_decode (
        .wr     (req.wr),
        .rd     (req.rd),
        .addr   (req.addr),
        .wr_sel (wr_sel),
        .rd_hit (rd_hit),
        .rd_idx (rd_idx)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        load_cmd_t cmd;
        assign cmd.load  = wr_sel[g];
        assign cmd.value = req.data;

        irp_channel #(.PEND_W(PEND_W)) u_ch (
            .clk    (clk),
            .rst    (rst),
            .cmd    (cmd),
            .pend   (pend_i[g*PEND_W +: PEND_W]),
            .shadow (shadows[g]),
            .irq    (irq_o[g])
        );
    end

    irp_rdmux #(.NUM_CH(NUM_CH)) u_rdmux (
        .clk    (clk),
        .rst    (rst),
        .rd     (req.rd),
        .hit    (rd_hit),
        .idx    (rd_idx),
        .values (shadows),
        .rdata  (rdata_o)
    );

endmodule

// File: rtl/irp_pacer_chk.sv
module irp_pacer_chk
    import irp_pkg::*;
#(
    parameter int    NUM_CH    = 8,
    parameter int    PEND_W    = 8,
    parameter addr_t BASE_ADDR = 16'h0320
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     wr_en_i,
    input logic [15:0]              addr_i,
    input logic [NUM_CH*PEND_W-1:0] pend_i,
    input logic [NUM_CH-1:0]        irq_o
);

    logic [NUM_CH-1:0] wr_hit;
    logic [NUM_CH-1:0] fired_q;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        assign wr_hit[g] = wr_en_i && slot_hit(addr_i, BASE_ADDR, NUM_CH)
                           && (slot_num(addr_i, BASE_ADDR) == g);

        always_ff @(posedge clk) begin
            if (rst)              fired_q[g] <= 1'b0;
            else if (wr_hit[g])   fired_q[g] <= 1'b0;
            else if (irq_o[g])    fired_q[g] <= 1'b1;
        end

        AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
            irq_o[g] |=> !irq_o[g]); // R7

        AST_PULSE_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
            $rose(irq_o[g]) |-> $past(|pend_i[g*PEND_W +: PEND_W])); // R5

        AST_WRITE_CANCELS: assert property (@(posedge clk) disable iff (rst)
            wr_hit[g] |=> !irq_o[g]); // R8

        AST_ONE_PER_ARM: assert property (@(posedge clk) disable iff (rst)
            fired_q[g] |-> !irq_o[g]); // R6
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (irq_o == '0)); // R1

endmodule

bind irp_pacer_top irp_pacer_chk #(
    .NUM_CH    (NUM_CH),
    .PEND_W    (PEND_W),
    .BASE_ADDR (BASE_ADDR)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .pend_i  (pend_i),
    .irq_o   (irq_o)
);

// File: tb/tb_irp_pacer_top.sv
module tb_irp_pacer_top;

    localparam int NCH = 8;
    localparam int PW  = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [15:0]       addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic [NCH*PW-1:0] pend = '0;
    logic [NCH-1:0]    irq;

    int n_chk  = 0;
    int n_fail = 0;

    irp_pacer_top dut (
        .clk     (clk),
        .rst     (rst),
        .wr_en_i (wr_en),
        .rd_en_i (rd_en),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .pend_i  (pend),
        .irq_o   (irq)
    );

    always #5 clk = ~clk;

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ch_addr(input int n);
        return 16'h0320 + 16'(4 * n);
    endfunction

    task automatic bus_wr(input logic [15:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input string req, input logic [15:0] a, input logic [31:0] exp);
        rd_en = 1'b1; addr = a;
        tick();
        rd_en = 1'b0;
        chk(req, rdata, exp);
    endtask

    // Watch irq for cycles 0..last after a write; pulse expected at cycle hit on channel n.
    task automatic watch(input string req, input int n, input int hit, input int last);
        for (int i = 0; i <= last; i++) begin
            chk(req, 32'(irq), (i == hit) ? 32'(1 << n) : 32'h0);
            if (i != last) tick();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        tick(); tick();
        rst = 1'b0;
        tick();

        // R1: quiet outputs and zero registers after reset
        chk("R1 irq after reset", 32'(irq), 32'h0);
        for (int n = 0; n < NCH; n++) bus_rd("R1 reset value", ch_addr(n), 32'h0);

        // R1/R5/R6/R7: every pacer starts armed; one pulse per pending rise
        for (int n = 0; n < NCH; n++) begin
            pend[n*PW +: PW] = 8'(1 << (n % PW));
            tick();
            chk("R1 armed out of reset", 32'(irq), 32'(1 << n));
            tick();
            chk("R7 one-cycle pulse", 32'(irq), 32'h0);
            tick(); tick();
            chk("R6 spent stays quiet", 32'(irq), 32'h0);
        end

        // R3/R4/R10: count sweep per channel with pending held high
        for (int n = 0; n < NCH; n++) begin
            int vals [5];
            vals = '{0, 1, 2, 5, n + 3};
            foreach (vals[j]) begin
                bus_wr(ch_addr(n), 32'(vals[j]));
                watch((vals[j] == 0) ? "R4 zero write" : "R3 countdown", n, vals[j] + 1, vals[j] + 3);
            end
        end

        // R5: expiry with nothing pending defers the pulse
        pend[5*PW +: PW] = '0;
        bus_wr(ch_addr(5), 32'd3);
        for (int i = 0; i < 10; i++) begin
            chk("R5 held while nothing pending", 32'(irq), 32'h0);
            tick();
        end
        pend[5*PW +: PW] = 8'h80;
        tick();
        chk("R5 pulse on late pending", 32'(irq), 32'(1 << 5));
        tick();
        chk("R5 single pulse", 32'(irq), 32'h0);

        // R8: write lands on the same edge as the pending rise of an armed pacer
        pend[2*PW +: PW] = '0;
        bus_wr(ch_addr(2), 32'd0);
        tick();
        chk("R8 armed waiting", 32'(irq), 32'h0);
        pend[2*PW +: PW] = 8'h04;
        bus_wr(ch_addr(2), 32'd4);
        watch("R8 write cancels pulse", 2, 5, 7);

        // R8: rewrite during a countdown restarts it
        bus_wr(ch_addr(6), 32'd10);
        for (int i = 0; i < 3; i++) begin
            chk("R8 mid countdown", 32'(irq), 32'h0);
            tick();
        end
        bus_wr(ch_addr(6), 32'd2);
        watch("R8 restart", 6, 3, 5);

        // R2: readback of distinct values on every channel
        pend = '0;
        for (int n = 0; n < NCH; n++) bus_wr(ch_addr(n), 32'h9000_0000 + 32'(n) * 32'h1111);
        for (int n = 0; n < NCH; n++) bus_rd("R2 readback", ch_addr(n), 32'h9000_0000 + 32'(n) * 32'h1111);

        // R9: stray addresses neither write nor read
        bus_wr(16'h0340, 32'h0);
        bus_wr(16'h031C, 32'h0);
        bus_wr(16'h0321, 32'h0);
        bus_wr(16'h0336, 32'h0);
        pend = '1;
        tick();
        chk("R9 no pulse from stray write", 32'(irq), 32'h0);
        for (int n = 0; n < NCH; n++) bus_rd("R9 unchanged", ch_addr(n), 32'h9000_0000 + 32'(n) * 32'h1111);
        bus_rd("R9 read above map", 16'h0340, 32'h0);
        bus_rd("R9 read below map", 16'h031C, 32'h0);
        bus_rd("R9 read misaligned", 16'h0322, 32'h0);

        // R10: one write on channel 4 leaves the others counting untouched
        bus_wr(ch_addr(4), 32'd1);
        watch("R10 isolated channel", 4, 2, 4);
        bus_rd("R10 neighbour value", ch_addr(3), 32'h9000_0000 + 32'd3 * 32'h1111);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule